// File: doc/BRIEF.md
# Rotational Sector Position Tracker

This block stands in for the spinning surface of a disk that has one head per track. A rotation counter moves forward one word slot every few clocks, and that number of clocks comes from a programmable word-time register. Word slots are grouped into sectors. The block reports which sector is under the heads right now, wrapping at the sectors-per-track count of the selected geometry. Geometry 0 has 82 sectors per track and geometry 1 has 12.

For a requested target sector, the block gives the rotational latency in word slots: the sector distance ahead of the heads, modulo the track length, multiplied by the words per sector. A one-shot timer can be started in two ways. One start counts down that latency. The other counts down a fixed inter-sector gap used between sectors of a multi-sector transfer. Either way, the block pulses a done flag when the countdown ends.

A transfer sequencer uses the block to decide when to begin moving a sector. The block carries no data.

Top module: `sector_clock`

## Requirements
- R1: After reset, `curSector` is 0, `timerDone` is 0, the word-time register holds 2, and `latencyWords` equals `targetSector` × words-per-sector.
- R2: Counting rising edges from reset release, or from the word-time load edge, a word tick occurs on edge n when n is a multiple of the effective word time. `curSector` equals floor(ticks / words-per-sector) modulo the sectors per track.
- R3: `geomSel` = 0 selects 82 sectors per track and `geomSel` = 1 selects 12. `curSector` wraps to 0 after the last sector of the selected geometry.
- R4: `latencyWords` = ((`targetSector` − `curSector`) mod sectors-per-track) × words-per-sector, computed combinationally.
- R5: A `startSeek` sampled while idle loads the latency. The counter then decrements on each later word tick. `timerDone` rises on the edge after the one that leaves the counter at zero.
- R6: When the target equals the current sector, the latency is zero. `timerDone` then rises on the edge right after the start edge, with no full-rotation wait.
- R7: A `startGap` sampled while idle loads a fixed gap of 16 word slots and times it out the same way as R5.
- R8: A `wtLoad` pulse writes `wtValue` into the word-time register and restarts the rotation at word 0, sector 0.
- R9: A word time of 0 behaves as a word time of 1.
- R10: Reset cancels a pending countdown: no `timerDone` follows the reset.
- R11: Starts that arrive while a countdown is running are ignored. If both starts arrive together while idle, the seek wins.
- R12: `timerDone` is high for exactly one clock per countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wtLoad | input | 1 | Write `wtValue` into the word-time register and restart rotation |
| wtValue | input | 8 | Clocks per word slot |
| geomSel | input | 1 | 0: 82 sectors per track, 1: 12 sectors per track |
| targetSector | input | 7 | Sector wanted next |
| startSeek | input | 1 | Start the latency countdown |
| startGap | input | 1 | Start the inter-sector gap countdown |
| curSector | output | 7 | Sector currently under the heads |
| latencyWords | output | 15 | Word slots until the target sector arrives |
| timerDone | output | 1 | One-clock pulse when a countdown ends |

## Verification
The position and latency logic is tried at several points in time. There are targets ahead of the heads and targets behind them, the second case forcing the modulo wrap. Both geometries are used. Word times of 0, 1, 2, 3 and 5 are used, with 2 coming from the reset default rather than a load.

A full-rotation point separates a correct track wrap from an off-by-one at the last sector. A zero-distance target separates immediate scheduling from a full-turn wait. The countdown is timed edge by edge against a model of word ticks, so a wrong prescaler phase or a missed decrement shows up as a wrong done cycle. A gap start injected during a running seek, and a reset during a countdown, show whether busy starts and stale timers are properly dropped.

// File: rtl/sector_clock_pkg.sv
package sector_clock_pkg;
  // Strobes from the sequencing control to the rotation datapath
  typedef struct packed {
    logic loadSeek;  // load countdown with current latency
    logic loadGap;   // load countdown with inter-sector gap
    logic countEn;   // countdown may decrement on word ticks
  } sc_strobe_t;

  typedef enum logic {
    SC_IDLE = 1'b0,
    SC_RUN  = 1'b1
  } sc_state_e;
endpackage

// File: rtl/sector_clock_datapath.sv
module sector_clock_datapath
  import sector_clock_pkg::*;
#(
  parameter int SPT_A            = 82,
  parameter int SPT_B            = 12,
  parameter int WORDS_PER_SECTOR = 256,
  parameter int GAP_WORDS        = 16,
  parameter int WT_W             = 8,
  parameter int DEFAULT_WT       = 2,
  localparam int SPT_MAX  = (SPT_A > SPT_B) ? SPT_A : SPT_B,
  localparam int SEC_W    = $clog2(SPT_MAX),
  localparam int WPS_W    = (WORDS_PER_SECTOR > 1) ? $clog2(WORDS_PER_SECTOR) : 1,
  localparam int LAT_SPAN = SPT_MAX * WORDS_PER_SECTOR,
  localparam int LAT_MAX  = (LAT_SPAN > GAP_WORDS) ? LAT_SPAN : GAP_WORDS,
  localparam int LAT_W    = $clog2(LAT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wtLoad,
  input  logic [WT_W-1:0]  wtValue,
  input  logic             geomSel,
  input  logic [SEC_W-1:0] targetSector,
  input  sc_strobe_t       strobe,
  output logic [SEC_W-1:0] curSector,
  output logic [LAT_W-1:0] latencyWords,
  output logic             timerZero
);

  logic [WT_W-1:0]  wordTimeReg;
  logic [WT_W-1:0]  prescale;
  logic [WPS_W-1:0] wordPos;
  logic [SEC_W-1:0] sector;
  logic [LAT_W-1:0] timerCnt;

  logic             wordTick;
  logic             wordPosLast;
  logic             sectorLast;
  logic [SEC_W:0]   sptSel;
  logic [SEC_W:0]   delta;

  assign sptSel      = geomSel ? (SEC_W+1)'(SPT_B) : (SEC_W+1)'(SPT_A);
  // word time 0 degenerates to a tick every clock
  assign wordTick    = ({1'b0, prescale} + (WT_W+1)'(1)) >= {1'b0, wordTimeReg};
  assign wordPosLast = (wordPos == WPS_W'(WORDS_PER_SECTOR - 1));
  assign sectorLast  = ({1'b0, sector} + (SEC_W+1)'(1)) >= sptSel;

  // Word-time register and rotation counters
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wordTimeReg <= WT_W'(DEFAULT_WT);
      prescale    <= '0;
      wordPos     <= '0;
      sector      <= '0;
    end else if (wtLoad) begin
      wordTimeReg <= wtValue;
      prescale    <= '0;
      wordPos     <= '0;
      sector      <= '0;
    end else begin
      prescale <= wordTick ? '0 : prescale + WT_W'(1);
      if (wordTick) begin
        if (wordPosLast) begin
          wordPos <= '0;
          sector  <= sectorLast ? '0 : sector + SEC_W'(1);
        end else begin
          wordPos <= wordPos + WPS_W'(1);
        end
      end
    end
  end

  // Sector distance modulo track length
  always_comb begin
    if ({1'b0, targetSector} >= {1'b0, sector})
      delta = {1'b0, targetSector} - {1'b0, sector};
    else
      delta = {1'b0, targetSector} + sptSel - {1'b0, sector};
  end

  // Scale sector distance to word slots: shift when a power of two
  generate
    if ((WORDS_PER_SECTOR & (WORDS_PER_SECTOR - 1)) == 0) begin : g_shiftScale
      localparam int SHIFT = $clog2(WORDS_PER_SECTOR);
      assign latencyWords = LAT_W'(delta) << SHIFT;
    end else begin : g_mulScale
      assign latencyWords = LAT_W'(delta) * LAT_W'(WORDS_PER_SECTOR);
    end
  endgenerate

  // One-shot countdown in word slots
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timerCnt <= '0;
    end else if (strobe.loadSeek) begin
      timerCnt <= latencyWords;
    end else if (strobe.loadGap) begin
      timerCnt <= LAT_W'(GAP_WORDS);
    end else if (strobe.countEn && wordTick && !timerZero) begin
      timerCnt <= timerCnt - LAT_W'(1);
    end
  end

  assign timerZero = (timerCnt == '0);
  assign curSector = sector;

endmodule

// File: rtl/sector_clock_ctrl.sv
module sector_clock_ctrl
  import sector_clock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startSeek,
  input  logic       startGap,
  input  logic       timerZero,
  output sc_strobe_t strobe,
  output logic       timerDone
);

  sc_state_e state;

  always_comb begin
    strobe = '0;
    case (state)
      SC_IDLE: begin
        if (startSeek)     strobe.loadSeek = 1'b1;
        else if (startGap) strobe.loadGap  = 1'b1;
      end
      SC_RUN:  strobe.countEn = 1'b1;
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SC_IDLE;
      timerDone <= 1'b0;
    end else begin
      timerDone <= 1'b0;
      case (state)
        SC_IDLE: if (startSeek || startGap) state <= SC_RUN;
        SC_RUN: begin
          if (timerZero) begin
            timerDone <= 1'b1;
            state     <= SC_IDLE;
          end
        end
        default: state <= SC_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sector_clock.sv
module sector_clock
  import sector_clock_pkg::*;
#(
  parameter int SPT_A            = 82,
  parameter int SPT_B            = 12,
  parameter int WORDS_PER_SECTOR = 256,
  parameter int GAP_WORDS        = 16,
  parameter int WT_W             = 8,
  parameter int DEFAULT_WT       = 2,
  localparam int SPT_MAX  = (SPT_A > SPT_B) ? SPT_A : SPT_B,
  localparam int SEC_W    = $clog2(SPT_MAX),
  localparam int LAT_SPAN = SPT_MAX * WORDS_PER_SECTOR,
  localparam int LAT_MAX  = (LAT_SPAN > GAP_WORDS) ? LAT_SPAN : GAP_WORDS,
  localparam int LAT_W    = $clog2(LAT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wtLoad,
  input  logic [WT_W-1:0]  wtValue,
  input  logic             geomSel,
  input  logic [SEC_W-1:0] targetSector,
  input  logic             startSeek,
  input  logic             startGap,
  output logic [SEC_W-1:0] curSector,
  output logic [LAT_W-1:0] latencyWords,
  output logic             timerDone
);

  sc_strobe_t strobe;
  logic       timerZero;

  sector_clock_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .startSeek (startSeek),
    .startGap  (startGap),
    .timerZero (timerZero),
    .strobe    (strobe),
    .timerDone (timerDone)
  );

  sector_clock_datapath #(
    .SPT_A            (SPT_A),
    .SPT_B            (SPT_B),
    .WORDS_PER_SECTOR (WORDS_PER_SECTOR),
    .GAP_WORDS        (GAP_WORDS),
    .WT_W             (WT_W),
    .DEFAULT_WT       (DEFAULT_WT)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .wtLoad       (wtLoad),
    .wtValue      (wtValue),
    .geomSel      (geomSel),
    .targetSector (targetSector),
    .strobe       (strobe),
    .curSector    (curSector),
    .latencyWords (latencyWords),
    .timerZero    (timerZero)
  );

endmodule

// File: rtl/sector_clock_checker.sv
module sector_clock_checker #(
  parameter int SPT_A            = 82,
  parameter int SPT_B            = 12,
  parameter int WORDS_PER_SECTOR = 256,
  parameter int SEC_W            = 7,
  parameter int LAT_W            = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             geomSel,
  input logic [SEC_W-1:0] targetSector,
  input logic             startSeek,
  input logic             startGap,
  input logic [SEC_W-1:0] curSector,
  input logic [LAT_W-1:0] latencyWords,
  input logic             timerDone
);

  logic [SEC_W:0] spt;
  logic           pending;

  assign spt = geomSel ? (SEC_W+1)'(SPT_B) : (SEC_W+1)'(SPT_A);

  // Checker-side record of an outstanding countdown
  always_ff @(posedge clk) begin
    if (!rst_n)                       pending <= 1'b0;
    else if (timerDone)               pending <= 1'b0;
    else if (startSeek || startGap)   pending <= 1'b1;
  end

  // R3: sector stays inside the selected track while geometry holds
  assert_sector_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(geomSel) == geomSel) && ({1'b0, $past(curSector)} < spt))
      |-> ({1'b0, curSector} < spt));

  // R2: sector only advances by one or wraps to zero
  assert_sector_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(curSector) |-> ((curSector == $past(curSector) + SEC_W'(1)) || (curSector == '0)));

  // R6: zero distance gives zero latency
  assert_zero_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (targetSector == curSector) |-> (latencyWords == '0));

  // R4: latency is less than one full rotation for a valid target
  assert_latency_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (({1'b0, targetSector} < spt) && ({1'b0, curSector} < spt))
      |-> (32'(latencyWords) < 32'(spt) * WORDS_PER_SECTOR));

  // R12: done is a single-clock pulse
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    timerDone |=> !timerDone);

  // R5 / R10: done only follows a start not cancelled by reset
  assert_done_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timerDone |-> pending);

endmodule

bind sector_clock sector_clock_checker #(
  .SPT_A            (SPT_A),
  .SPT_B            (SPT_B),
  .WORDS_PER_SECTOR (WORDS_PER_SECTOR),
  .SEC_W            (SEC_W),
  .LAT_W            (LAT_W)
) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .geomSel      (geomSel),
  .targetSector (targetSector),
  .startSeek    (startSeek),
  .startGap     (startGap),
  .curSector    (curSector),
  .latencyWords (latencyWords),
  .timerDone    (timerDone)
);

// File: tb/sector_clock_test.sv
module sector_clock_test;
  localparam int WPS   = 8;
  localparam int GAP   = 16;
  localparam int SEC_W = 7;
  localparam int LAT_W = $clog2(82 * WPS + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wtLoad = 1'b0;
  logic [7:0]       wtValue = '0;
  logic             geomSel = 1'b0;
  logic [SEC_W-1:0] targetSector = '0;
  logic             startSeek = 1'b0;
  logic             startGap = 1'b0;
  logic [SEC_W-1:0] curSector;
  logic [LAT_W-1:0] latencyWords;
  logic             timerDone;

  int checks = 0;
  int fails = 0;
  int clkCount = 0;
  int cycles = 0;
  bit finished = 1'b0;

  sector_clock #(.WORDS_PER_SECTOR(WPS), .GAP_WORDS(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .wtLoad(wtLoad), .wtValue(wtValue),
    .geomSel(geomSel), .targetSector(targetSector), .startSeek(startSeek),
    .startGap(startGap), .curSector(curSector), .latencyWords(latencyWords),
    .timerDone(timerDone)
  );

  always #5 clk = ~clk;

  // vector: geometry, word time, clocks to wait, target, expected sector
  typedef struct packed {
    logic       geom;
    logic [7:0] wt;
    logic [15:0] waitClk;
    logic [6:0] target;
    logic [6:0] expSec;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 8'd2,  16'd40,   7'd10, 7'd2},
    '{1'b0, 8'd2,  16'd40,   7'd1,  7'd2},
    '{1'b1, 8'd2,  16'd200,  7'd3,  7'd0},
    '{1'b1, 8'd3,  16'd500,  7'd5,  7'd8},
    '{1'b0, 8'd1,  16'd100,  7'd12, 7'd12},
    '{1'b1, 8'd0,  16'd37,   7'd11, 7'd4},
    '{1'b0, 8'd5,  16'd1000, 7'd0,  7'd25},
    '{1'b0, 8'd2,  16'd2624, 7'd81, 7'd0}
  };

  function automatic int spt(input logic g);
    return g ? 12 : 82;
  endfunction

  function automatic int expLatency(input int tgt, input int cur, input logic g);
    int d;
    d = tgt - cur;
    if (d < 0) d = d + spt(g);
    return d * WPS;
  endfunction

  task automatic tick();
    @(negedge clk);
    clkCount++;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    startSeek = 1'b0;
    startGap = 1'b0;
    wtLoad = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
    clkCount = 0;
  endtask

  task automatic loadWordTime(input logic [7:0] v);
    wtValue = v;
    wtLoad = 1'b1;
    tick();
    wtLoad = 1'b0;
    clkCount = 0;
  endtask

  // Starts a countdown and times it against a word-tick model
  task automatic runTimer(input bit gap, input int len, input int wtEff,
                          input bit interfere, input string req);
    int remaining;
    bit early;
    bit seen;
    early = 1'b0;
    seen = 1'b0;
    remaining = len;
    if (gap) startGap = 1'b1; else startSeek = 1'b1;
    tick();
    startSeek = 1'b0;
    startGap = 1'b0;
    for (int iter = 0; iter < 20000; iter++) begin
      startGap = (interfere && iter == 2);
      tick();
      startGap = 1'b0;
      if (remaining == 0) begin
        seen = (timerDone == 1'b1);
        break;
      end
      if (timerDone) early = 1'b1;
      if ((clkCount % wtEff) == 0) remaining--;
    end
    check(!early && seen, req, int'(seen), 1);
    tick();
    check(timerDone == 1'b0, "R12 done lasts one clock", int'(timerDone), 0);
  endtask

  initial begin
    while (!finished && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int wtEff;
    int lat;
    // R1: reset state
    geomSel = 1'b0;
    targetSector = 7'd5;
    doReset();
    check(curSector == '0, "R1 sector after reset", int'(curSector), 0);
    check(timerDone == 1'b0, "R1 done after reset", int'(timerDone), 0);
    check(int'(latencyWords) == 5 * WPS, "R1 latency after reset", int'(latencyWords), 5 * WPS);

    // Vector table: R2 R3 R4 R8 R9 position and latency, R5 R6 countdown
    for (int i = 0; i < 8; i++) begin
      geomSel = VECS[i].geom;
      targetSector = VECS[i].target;
      doReset();
      if (VECS[i].wt != 8'd2) loadWordTime(VECS[i].wt);
      wtEff = (VECS[i].wt == 0) ? 1 : int'(VECS[i].wt);
      for (int k = 0; k < int'(VECS[i].waitClk); k++) tick();
      check(int'(curSector) == int'(VECS[i].expSec),
            "R2 R3 R8 R9 current sector", int'(curSector), int'(VECS[i].expSec));
      lat = expLatency(int'(VECS[i].target), int'(VECS[i].expSec), VECS[i].geom);
      check(int'(latencyWords) == lat, "R4 latency", int'(latencyWords), lat);
      runTimer(1'b0, lat, wtEff, 1'b0, (lat == 0) ? "R6 immediate done" : "R5 seek done timing");
    end

    // R7: inter-sector gap countdown
    geomSel = 1'b1;
    doReset();
    for (int k = 0; k < 7; k++) tick();
    runTimer(1'b1, GAP, 2, 1'b0, "R7 gap done timing");

    // R11: a gap start during a running seek is ignored
    targetSector = 7'd6;
    doReset();
    for (int k = 0; k < 3; k++) tick();
    lat = expLatency(6, 0, 1'b1);
    check(int'(latencyWords) == lat, "R11 latency before start", int'(latencyWords), lat);
    runTimer(1'b0, lat, 2, 1'b1, "R11 busy start ignored");

    // R11: simultaneous starts, seek wins
    targetSector = 7'd3;
    doReset();
    startGap = 1'b1;
    runTimer(1'b0, 3 * WPS, 2, 1'b0, "R11 seek priority");

    // R10: reset cancels a pending countdown
    geomSel = 1'b0;
    targetSector = 7'd40;
    doReset();
    startSeek = 1'b1;
    tick();
    startSeek = 1'b0;
    for (int k = 0; k < 10; k++) tick();
    doReset();
    check(curSector == '0, "R10 sector after reset", int'(curSector), 0);
    begin
      bit sawDone;
      sawDone = 1'b0;
      targetSector = 7'd0;
      for (int k = 0; k < 900; k++) begin
        tick();
        if (timerDone) sawDone = 1'b1;
      end
      check(!sawDone, "R10 no done after reset", int'(sawDone), 0);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule